// File: doc/BRIEF.md
# Raster line interrupt generator

This block produces the processor interrupt request for a video subsystem. It watches the horizontal and vertical beam counters of an external video timing generator. It raises a request when the beam reaches a line chosen by software. It combines that request with the legacy once-per-frame interrupt that the timing generator already supplies.

Software controls the block through a small register port with four registers:

| Address | Contents |
|---|---|
| 0 | Control |
| 1 | Low byte of the target line |
| 2 | Line numbering offset |
| 3 | Alias of the two enable bits |

Line numbers count from the first line of the pixel area. The vertical counter input uses that same numbering.

The request does not wait for the target line to begin. It fires in the horizontal blanking that follows the 256-pixel active area of the line before the target. It stays high only while the horizontal position is inside that blanking window. This leaves the interrupt handler the blanking time before the target line starts. No acknowledge handshake exists: the request simply drops when the beam leaves the window.

The register port carries single-cycle writes and combinational reads. It has no valid/ready handshake, so it never applies back-pressure: a write strobe is always taken in the cycle it is presented. The beam counters and the frame request are plain level inputs.

Top module: `raster_irq_gen`

## Requirements
- R1: After reset, registers 0, 1, 2 and 3 read back bits 6 to 0 as 0, and `irq` is 0.
- R2: The 9-bit target line is formed from control bit 0 (the most significant bit) and register 1 (the low eight bits). Both read back as written.
- R3: Control bits 6 to 3 always read as 0, whatever is written to them. Bit 7 of a write to the control register has no effect.
- R4: With control bit 1 (line enable) set, `irq` is 1 in the cycle after one in which two conditions hold. The adjusted line must equal the target minus 1, where a target of 0 means line `LINES_TOTAL-1`. The horizontal position must be in 256..319 inclusive.
- R5: No line request occurs when the horizontal position is outside 256..319, when the adjusted line is any other line, or when line enable is 0.
- R6: The adjusted line is (vertical position minus register 2) modulo `LINES_TOTAL`.
- R7: `frame_req` reaches `irq` one cycle later when control bit 2 is 0. Control bit 2 set to 1 suppresses it.
- R8: Control bit 7 on read returns the present value of `irq`.
- R9: Register 3 bit 0 is the same storage as control bit 1, and register 3 bit 1 is the same storage as control bit 2. A write through either address is seen at both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hpos | input | H_W | Horizontal beam position in standard pixels |
| vpos | input | V_W | Vertical line, 0 = first pixel-area line |
| frame_req | input | 1 | Legacy frame interrupt request |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational from reg_addr) |
| irq | output | 1 | Interrupt request, active high |

## Verification
Four properties are checked on every cycle:
- No request appears outside the horizontal window unless an unsuppressed frame request is present.
- An unsuppressed frame request always reaches the output.
- A cleared line enable with no frame request leaves the output low.
- Control reads show zero reserved bits and the live request in bit 7.

Only the bench's sweeps can show that the request lands on exactly the line before the target. The sweeps cover every line of the frame under several targets and offsets, including the wrap of target 0 and targets beyond the frame. The bench also covers the register aliasing.

// File: rtl/raster_irq_pkg.sv
`timescale 1ns/1ps
package raster_irq_pkg;
  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_LINE   = 2'd1;
  localparam logic [1:0] ADDR_OFFSET = 2'd2;
  localparam logic [1:0] ADDR_ALIAS  = 2'd3;

  typedef struct packed {
    logic       frame_dis;
    logic       line_en;
    logic [8:0] target;
  } irq_cfg_t;
endpackage

// File: rtl/raster_irq_regs.sv
`timescale 1ns/1ps
module raster_irq_regs
  import raster_irq_pkg::*;
#(
  parameter int OFS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [1:0]       addr,
  input  logic [7:0]       wdata,
  input  logic             irq_live,
  output logic [7:0]       rdata,
  output irq_cfg_t         cfg,
  output logic [OFS_W-1:0] offset
);
  irq_cfg_t         cfg_q;
  logic [OFS_W-1:0] ofs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      ofs_q <= '0;
    end else if (we) begin
      unique case (addr)
        ADDR_CTRL: begin
          cfg_q.target[8] <= wdata[0];
          cfg_q.line_en   <= wdata[1];
          cfg_q.frame_dis <= wdata[2];
        end
        ADDR_LINE:   cfg_q.target[7:0] <= wdata;
        ADDR_OFFSET: ofs_q <= wdata[OFS_W-1:0];
        ADDR_ALIAS: begin
          cfg_q.line_en   <= wdata[0];
          cfg_q.frame_dis <= wdata[1];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      ADDR_CTRL:   rdata = {irq_live, 4'b0000, cfg_q.frame_dis, cfg_q.line_en, cfg_q.target[8]};
      ADDR_LINE:   rdata = cfg_q.target[7:0];
      ADDR_OFFSET: rdata = 8'(ofs_q);
      ADDR_ALIAS:  rdata = {6'b0, cfg_q.frame_dis, cfg_q.line_en};
      default:     rdata = '0;
    endcase
  end

  assign cfg    = cfg_q;
  assign offset = ofs_q;
endmodule

// File: rtl/raster_irq_match.sv
`timescale 1ns/1ps
module raster_irq_match #(
  parameter int H_W         = 9,
  parameter int V_W         = 9,
  parameter int OFS_W       = 8,
  parameter int LINES_TOTAL = 312,
  parameter int WIN_FIRST   = 256,
  parameter int WIN_LAST    = 319
) (
  input  logic [H_W-1:0]   hpos,
  input  logic [V_W-1:0]   vpos,
  input  logic [OFS_W-1:0] offset,
  input  logic [8:0]       target,
  input  logic             line_en,
  output logic             hit
);
  localparam int CW = ((V_W > 9) ? V_W : 9) + 2;

  logic [CW-1:0] v_ext, o_ext, adj_line, prev_line;
  logic          in_win;

  always_comb begin
    v_ext = CW'(vpos);
    o_ext = CW'(offset);
    if (v_ext >= o_ext) adj_line = v_ext - o_ext;
    else                adj_line = v_ext + CW'(LINES_TOTAL) - o_ext;
    if (target == 9'd0) prev_line = CW'(LINES_TOTAL - 1);
    else                prev_line = CW'(target) - CW'(1);
    in_win = (hpos >= H_W'(WIN_FIRST)) && (hpos <= H_W'(WIN_LAST));
    hit    = line_en && in_win && (adj_line == prev_line);
  end
endmodule

// File: rtl/raster_irq_merge.sv
`timescale 1ns/1ps
module raster_irq_merge (
  input  logic clk,
  input  logic rst_n,
  input  logic line_hit,
  input  logic frame_req,
  input  logic frame_dis,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= line_hit | (frame_req & ~frame_dis);
  end
endmodule

// File: rtl/raster_irq_gen.sv
`timescale 1ns/1ps
module raster_irq_gen
  import raster_irq_pkg::*;
#(
  parameter int H_W         = 9,
  parameter int V_W         = 9,
  parameter int OFS_W       = 8,
  parameter int LINES_TOTAL = 312,
  parameter int WIN_FIRST   = 256,
  parameter int WIN_LAST    = 319
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [H_W-1:0] hpos,
  input  logic [V_W-1:0] vpos,
  input  logic           frame_req,
  input  logic           reg_we,
  input  logic [1:0]     reg_addr,
  input  logic [7:0]     reg_wdata,
  output logic [7:0]     reg_rdata,
  output logic           irq
);
  irq_cfg_t         cfg;
  logic [OFS_W-1:0] offset;
  logic             line_hit;
  logic             line_en;
  logic             frame_dis;

  raster_irq_regs #(.OFS_W(OFS_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .irq_live(irq), .rdata(reg_rdata), .cfg(cfg), .offset(offset)
  );

  assign line_en   = cfg.line_en;
  assign frame_dis = cfg.frame_dis;

  raster_irq_match #(
    .H_W(H_W), .V_W(V_W), .OFS_W(OFS_W), .LINES_TOTAL(LINES_TOTAL),
    .WIN_FIRST(WIN_FIRST), .WIN_LAST(WIN_LAST)
  ) u_match (
    .hpos(hpos), .vpos(vpos), .offset(offset), .target(cfg.target),
    .line_en(line_en), .hit(line_hit)
  );

  raster_irq_merge u_merge (
    .clk(clk), .rst_n(rst_n), .line_hit(line_hit), .frame_req(frame_req),
    .frame_dis(frame_dis), .irq(irq)
  );
endmodule

// File: rtl/raster_irq_chk.sv
`timescale 1ns/1ps
module raster_irq_chk #(
  parameter int H_W       = 9,
  parameter int WIN_FIRST = 256,
  parameter int WIN_LAST  = 319
) (
  input logic           clk,
  input logic           rst_n,
  input logic [H_W-1:0] hpos,
  input logic           frame_req,
  input logic           line_en,
  input logic           frame_dis,
  input logic [1:0]     reg_addr,
  input logic [7:0]     reg_rdata,
  input logic           irq
);
  logic outside;
  assign outside = (hpos < H_W'(WIN_FIRST)) || (hpos > H_W'(WIN_LAST));

  // R5: no request outside the window without an unsuppressed frame request
  assert_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (outside && (!frame_req || frame_dis)) |=> !irq);

  // R7: unsuppressed frame request always reaches the output
  assert_frame_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_req && !frame_dis) |=> irq);

  // R5: line enable cleared and no frame request means no request
  assert_line_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_en && !frame_req) |=> !irq);

  // R3: reserved control bits read as zero
  assert_reserved_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd0) |-> (reg_rdata[6:3] == 4'b0000));

  // R8: control bit 7 mirrors the live request
  assert_live_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd0) |-> (reg_rdata[7] == irq));
endmodule

bind raster_irq_gen raster_irq_chk #(.H_W(H_W), .WIN_FIRST(WIN_FIRST), .WIN_LAST(WIN_LAST)) u_chk (
  .clk(clk), .rst_n(rst_n), .hpos(hpos), .frame_req(frame_req), .line_en(line_en),
  .frame_dis(frame_dis), .reg_addr(reg_addr), .reg_rdata(reg_rdata), .irq(irq)
);

// File: tb/raster_irq_gen_tb.sv
`timescale 1ns/1ps
module raster_irq_gen_tb;
  localparam int L = 312;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] hpos = '0;
  logic [8:0] vpos = '0;
  logic       frame_req = 1'b0;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  raster_irq_gen u_dut (
    .clk(clk), .rst_n(rst_n), .hpos(hpos), .vpos(vpos), .frame_req(frame_req),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_check(input logic [1:0] a, input logic [7:0] mask, input logic [7:0] exp,
                          input string req);
    reg_addr = a;
    #1;
    check((reg_rdata & mask) == exp, req, int'(reg_rdata & mask), int'(exp));
  endtask

  function automatic bit exp_hit(input int v, input int h, input int off, input int t,
                                 input bit en);
    int adj, want;
    adj  = ((v - off) % L + L) % L;
    want = (t + L - 1) % L;
    return en && (h >= 256) && (h <= 319) && (t < L) && (adj == want);
  endfunction

  task automatic sweep(input int t, input int off, input bit en, input string req);
    int hs[4] = '{255, 256, 319, 320};
    wr(2'd0, {5'b0, 1'b0, en, 1'(t >> 8)});
    wr(2'd1, 8'(t));
    wr(2'd2, 8'(off));
    for (int v = 0; v < L; v++) begin
      for (int k = 0; k < 4; k++) begin
        hpos = 9'(hs[k]); vpos = 9'(v);
        @(negedge clk);
        check(irq == exp_hit(v, hs[k], off, t, en), req, int'(irq),
              int'(exp_hit(v, hs[k], off, t, en)));
      end
    end
  endtask

  initial begin
    int tg[6] = '{0, 1, 100, 256, 311, 400};
    int of[3] = '{0, 5, 200};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(irq == 1'b0, "R1", int'(irq), 0);
    rd_check(2'd0, 8'h7f, 8'h00, "R1");
    rd_check(2'd1, 8'hff, 8'h00, "R1");
    rd_check(2'd2, 8'hff, 8'h00, "R1");
    rd_check(2'd3, 8'hff, 8'h00, "R1");

    // R2 target readback; R3 reserved and bit 7 ignored
    wr(2'd0, 8'hf9);
    rd_check(2'd0, 8'h7f, 8'h01, "R3");
    wr(2'd1, 8'ha5);
    rd_check(2'd1, 8'hff, 8'ha5, "R2");
    rd_check(2'd0, 8'h01, 8'h01, "R2");

    // R9 alias both ways
    wr(2'd0, 8'h06);
    rd_check(2'd3, 8'h03, 8'h03, "R9");
    wr(2'd3, 8'h01);
    rd_check(2'd0, 8'h06, 8'h02, "R9");
    wr(2'd3, 8'h02);
    rd_check(2'd0, 8'h06, 8'h04, "R9");
    wr(2'd0, 8'h00);
    rd_check(2'd3, 8'h03, 8'h00, "R9");

    // R7 frame request pass and suppress
    hpos = 9'd10; vpos = 9'd50;
    frame_req = 1'b1;
    @(negedge clk);
    check(irq == 1'b1, "R7", int'(irq), 1);
    rd_check(2'd0, 8'h80, 8'h80, "R8");
    wr(2'd0, 8'h04);
    @(negedge clk);
    check(irq == 1'b0, "R7", int'(irq), 0);
    rd_check(2'd0, 8'h80, 8'h00, "R8");
    frame_req = 1'b0;
    wr(2'd0, 8'h00);

    // R8 live bit during a line request
    wr(2'd1, 8'd20);
    wr(2'd0, 8'h02);
    hpos = 9'd300; vpos = 9'd19;
    @(negedge clk);
    rd_check(2'd0, 8'h80, 8'h80, "R8");
    hpos = 9'd400;
    @(negedge clk);
    rd_check(2'd0, 8'h80, 8'h00, "R8");

    // R4/R5/R6 sweeps over every line
    foreach (tg[i]) sweep(tg[i], 0, 1'b1, "R4");
    foreach (of[j]) if (j > 0) begin
      sweep(0, of[j], 1'b1, "R6");
      sweep(100, of[j], 1'b1, "R6");
      sweep(311, of[j], 1'b1, "R6");
    end
    sweep(100, 0, 1'b0, "R5");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule